// File: doc/BRIEF.md
# Programmable Chip Select Unit

This unit turns a processor bus address into one of eight active-low external chip selects. Each select owns a base address, an address mask and a control word. The control word holds an enable, a port width code, a burst-capable flag, a wait-state count and an SDRAM-bank flag. When the bus raises a request, the unit compares the address against every live select and picks the lowest-numbered match. It then drives that select together with the direction strobe, the port width and the burst flag. It holds the select for the programmed number of wait clocks and closes the access with a one-clock transfer acknowledge.

Select 0 is the boot select. Reset leaves it enabled with an all-ones mask, so every address reaches it. It comes up with the slowest wait setting and takes its width from a two-bit strap that is sampled while reset is high. Reset leaves every other select disabled, and none of them drives until software writes its enable bit. Software can move select 0 to a new window at any time. Only select 7 may be marked as the SDRAM bank. A select carrying that mark is left to an external SDRAM controller and is skipped by this decode.

Top module: `chipsel_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, every select output is high and acknowledge is low. Reset leaves select 0 enabled with base 0, an all-ones mask and 15 wait states. All other selects come out of reset with their registers cleared, so they are disabled.
- R2: Width codes are 00 = 32 bits, 01 = 8 bits, 10 = 16 bits, and 11 is reserved and reported as 00. Reset loads select 0's width from the strap using these codes, with 11 stored as 00.
- R3: A select matches when `(addr ^ base) & ~mask` is zero.
- R4: A select whose enable bit is clear never asserts. A request that matches no live select asserts no select and no acknowledge.
- R5: When several live selects match, the lowest-numbered one drives.
- R6: A select asserts on the cycle after the request is sampled. With W programmed wait states, acknowledge is high for exactly one cycle, in the (W+2)-th cycle of assertion, and the select releases on the next cycle.
- R7: The direction output is 0 for a read and 1 for a write, and it is held for the whole access.
- R8: During an access, the port width output and the burst flag show the matched select's programmed values.
- R9: Control bit 8 (SDRAM mode) is stored only for select 7; on any other select a write of that bit is ignored. While select 7 holds that bit, it takes no part in the decode.
- R10: Register slot 0 holds the base, slot 1 the mask and slot 2 the control word. The control word layout is bit 0 enable, bits 2:1 width, bit 3 burst, bits 7:4 wait, bit 8 SDRAM. The read data shows the addressed register one clock after the index and slot are presented.
- R11: Requests that arrive while an access is in progress are ignored.
- R12: At most one select output is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_width_i | input | 2 | Strap for select 0's width, sampled during reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_idx_i | input | 3 | Select number for a register access |
| cfg_reg_i | input | 2 | Register slot: 0 base, 1 mask, 2 control |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Registered read data for the addressed register |
| bus_req_i | input | 1 | Access request, sampled while idle |
| bus_addr_i | input | 32 | Access address |
| bus_write_i | input | 1 | 1 for a write access, 0 for a read |
| cs_n_o | output | 8 | Active-low chip selects |
| dir_wr_o | output | 1 | Direction: 0 read, 1 write (1 while idle) |
| port_width_o | output | 2 | Width code of the matched select |
| burst_ok_o | output | 1 | Burst-capable flag of the matched select |
| xfer_ack_o | output | 1 | One-clock transfer acknowledge |

## Verification
A corrupted match or priority result shows up on the very cycle after the request: a different select line falls, or no line falls when one should. A wrong wait counter is invisible until the acknowledge arrives early or late, so each access is timed from the falling select edge to the acknowledge cycle. Register state that the decode never reads, such as a wrongly stored SDRAM flag, is exposed through the read data one clock later and through the next access to that window.

// File: rtl/chipsel_pkg.sv
package chipsel_pkg;
  parameter int WS_W = 4;

  // control word, bit 0 first: en, width[1:0], burst, wst, sdram
  typedef struct packed {
    logic            sdram;
    logic [WS_W-1:0] wst;
    logic            burst;
    logic [1:0]      width;
    logic            en;
  } cs_cfg_t;

  localparam int CTRL_W = $bits(cs_cfg_t);

  localparam logic [1:0] REG_BASE = 2'd0;
  localparam logic [1:0] REG_MASK = 2'd1;
  localparam logic [1:0] REG_CTRL = 2'd2;

  localparam logic [1:0] WD_32 = 2'b00;
  localparam logic [1:0] WD_8  = 2'b01;
  localparam logic [1:0] WD_16 = 2'b10;

  function automatic logic [1:0] norm_width(input logic [1:0] code);
    return (code == 2'b11) ? WD_32 : code;
  endfunction
endpackage

// File: rtl/cs_regfile.sv
module cs_regfile
  import chipsel_pkg::*;
#(
  parameter int NUM_CS    = 8,
  parameter int AW        = 32,
  parameter int SDRAM_IDX = 7,
  localparam int IDX_W    = $clog2(NUM_CS)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [1:0]                   strap_i,
  input  logic                         we_i,
  input  logic [IDX_W-1:0]             idx_i,
  input  logic [1:0]                   slot_i,
  input  logic [AW-1:0]                wdata_i,
  output logic [AW-1:0]                rdata_o,
  output logic [NUM_CS-1:0][AW-1:0]    base_o,
  output logic [NUM_CS-1:0][AW-1:0]    mask_o,
  output cs_cfg_t [NUM_CS-1:0]         cfg_o
);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_sel
    logic    hit;
    cs_cfg_t wr_cfg;
    assign hit    = we_i && (idx_i == IDX_W'(g));
    assign wr_cfg = cs_cfg_t'(wdata_i[CTRL_W-1:0]);

    always_ff @(posedge clk) begin
      if (rst) begin
        if (g == 0) begin
          // boot window: whole address space, slowest timing
          base_o[g] <= '0;
          mask_o[g] <= '1;
          cfg_o[g]  <= '{sdram: 1'b0, wst: {WS_W{1'b1}}, burst: 1'b0,
                         width: norm_width(strap_i), en: 1'b1};
        end else begin
          base_o[g] <= '0;
          mask_o[g] <= '0;
          cfg_o[g]  <= '0;
        end
      end else if (hit) begin
        case (slot_i)
          REG_BASE: base_o[g] <= wdata_i;
          REG_MASK: mask_o[g] <= wdata_i;
          REG_CTRL: begin
            cfg_o[g]       <= wr_cfg;
            cfg_o[g].sdram <= (g == SDRAM_IDX) ? wr_cfg.sdram : 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else begin
      case (slot_i)
        REG_BASE: rdata_o <= base_o[idx_i];
        REG_MASK: rdata_o <= mask_o[idx_i];
        REG_CTRL: rdata_o <= AW'(cfg_o[idx_i]);
        default:  rdata_o <= '0;
      endcase
    end
  end

endmodule

// File: rtl/cs_decode.sv
module cs_decode #(
  parameter int NUM_CS = 8,
  parameter int AW     = 32,
  localparam int IDX_W = $clog2(NUM_CS)
) (
  input  logic [AW-1:0]              addr_i,
  input  logic [NUM_CS-1:0][AW-1:0]  base_i,
  input  logic [NUM_CS-1:0][AW-1:0]  mask_i,
  input  logic [NUM_CS-1:0]          live_i,
  output logic                       hit_o,
  output logic [IDX_W-1:0]           idx_o
);

  logic [NUM_CS-1:0] match;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cmp
    assign match[g] = live_i[g] && (((addr_i ^ base_i[g]) & ~mask_i[g]) == '0);
  end

  // scan downward so the lowest-numbered match is the last one kept
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/cs_xfer.sv
module cs_xfer
  import chipsel_pkg::*;
#(
  parameter int NUM_CS = 8,
  localparam int IDX_W = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic              write_i,
  input  logic              hit_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [1:0]        width_i,
  input  logic              burst_i,
  input  logic [WS_W-1:0]   wst_i,
  output logic [NUM_CS-1:0] cs_n_o,
  output logic              dir_wr_o,
  output logic [1:0]        width_o,
  output logic              burst_o,
  output logic              ack_o
);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_ACK} st_t;

  st_t             state;
  logic [WS_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      cs_n_o   <= '1;
      dir_wr_o <= 1'b1;
      width_o  <= WD_32;
      burst_o  <= 1'b0;
      ack_o    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_i && hit_i) begin
            cs_n_o   <= ~(NUM_CS'(1) << idx_i);
            dir_wr_o <= write_i;
            width_o  <= norm_width(width_i);
            burst_o  <= burst_i;
            cnt      <= wst_i;
            state    <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (cnt == '0) begin
            ack_o <= 1'b1;
            state <= ST_ACK;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          ack_o    <= 1'b0;
          cs_n_o   <= '1;
          dir_wr_o <= 1'b1;
          width_o  <= WD_32;
          burst_o  <= 1'b0;
          state    <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/chipsel_unit.sv
module chipsel_unit
  import chipsel_pkg::*;
#(
  parameter int NUM_CS    = 8,
  parameter int AW        = 32,
  parameter int SDRAM_IDX = 7,
  localparam int IDX_W    = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        boot_width_i,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [1:0]        cfg_reg_i,
  input  logic [AW-1:0]     cfg_wdata_i,
  output logic [AW-1:0]     cfg_rdata_o,
  input  logic              bus_req_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic              bus_write_i,
  output logic [NUM_CS-1:0] cs_n_o,
  output logic              dir_wr_o,
  output logic [1:0]        port_width_o,
  output logic              burst_ok_o,
  output logic              xfer_ack_o
);

  logic [NUM_CS-1:0][AW-1:0] base;
  logic [NUM_CS-1:0][AW-1:0] mask;
  cs_cfg_t [NUM_CS-1:0]      cfg;
  logic [NUM_CS-1:0]         live;
  logic                      hit;
  logic [IDX_W-1:0]          win;
  cs_cfg_t                   win_cfg;

  cs_regfile #(.NUM_CS(NUM_CS), .AW(AW), .SDRAM_IDX(SDRAM_IDX)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .strap_i (boot_width_i),
    .we_i    (cfg_we_i),
    .idx_i   (cfg_idx_i),
    .slot_i  (cfg_reg_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .base_o  (base),
    .mask_o  (mask),
    .cfg_o   (cfg)
  );

  // an SDRAM-marked select belongs to the external SDRAM controller
  for (genvar g = 0; g < NUM_CS; g++) begin : g_live
    assign live[g] = cfg[g].en && !cfg[g].sdram;
  end

  cs_decode #(.NUM_CS(NUM_CS), .AW(AW)) u_dec (
    .addr_i (bus_addr_i),
    .base_i (base),
    .mask_i (mask),
    .live_i (live),
    .hit_o  (hit),
    .idx_o  (win)
  );

  assign win_cfg = cfg[win];

  cs_xfer #(.NUM_CS(NUM_CS)) u_xfer (
    .clk      (clk),
    .rst      (rst),
    .req_i    (bus_req_i),
    .write_i  (bus_write_i),
    .hit_i    (hit),
    .idx_i    (win),
    .width_i  (win_cfg.width),
    .burst_i  (win_cfg.burst),
    .wst_i    (win_cfg.wst),
    .cs_n_o   (cs_n_o),
    .dir_wr_o (dir_wr_o),
    .width_o  (port_width_o),
    .burst_o  (burst_ok_o),
    .ack_o    (xfer_ack_o)
  );

endmodule

// File: rtl/chipsel_unit_chk.sv
module chipsel_unit_chk #(
  parameter int NUM_CS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CS-1:0] cs_n,
  input logic              dir_wr,
  input logic              xfer_ack
);

  // R12: never two selects at once
  a_r12_one_select: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));

  // R1: idle outputs on the cycle after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> ((&cs_n) && !xfer_ack));

  // R6: acknowledge lasts one cycle and only inside an access
  a_r6_ack_single: assert property (@(posedge clk) disable iff (rst)
    xfer_ack |=> !xfer_ack);

  a_r6_ack_inside: assert property (@(posedge clk) disable iff (rst)
    xfer_ack |-> !(&cs_n));

  a_r6_release_after_ack: assert property (@(posedge clk) disable iff (rst)
    xfer_ack |=> (&cs_n));

  a_r6_no_ack_on_entry: assert property (@(posedge clk) disable iff (rst)
    $fell(&cs_n) |-> !xfer_ack);

  // R7: direction and select stay put until the acknowledge
  a_r7_held_in_access: assert property (@(posedge clk) disable iff (rst)
    (!(&cs_n) && !xfer_ack) |=> ($stable(dir_wr) && $stable(cs_n)));

endmodule

bind chipsel_unit chipsel_unit_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cs_n     (cs_n_o),
  .dir_wr   (dir_wr_o),
  .xfer_ack (xfer_ack_o)
);

// File: tb/chipsel_unit_tb_top.sv
`timescale 1ns/1ps
module chipsel_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  strap = 2'b01;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [1:0]  cfg_reg = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        bus_req = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_write = 1'b0;
  logic [7:0]  cs_n;
  logic        dir_wr;
  logic [1:0]  pwidth;
  logic        burst;
  logic        ack;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  chipsel_unit dut_i (
    .clk(clk), .rst(rst), .boot_width_i(strap),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_reg_i(cfg_reg),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .bus_req_i(bus_req), .bus_addr_i(bus_addr), .bus_write_i(bus_write),
    .cs_n_o(cs_n), .dir_wr_o(dir_wr), .port_width_o(pwidth),
    .burst_ok_o(burst), .xfer_ack_o(ack)
  );

  typedef struct {
    int         idx;
    bit         wr;
    logic [1:0] wd;
    bit         bst;
    int         wst;
    string      tag;
  } exp_t;

  exp_t q[$];

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ---------------- monitor: pops one expected item per access -------------
  bit   in_x = 1'b0;
  bit   ack_seen = 1'b0;
  int   cyc = 0;
  exp_t cur;

  always @(negedge clk) begin
    if (rst) begin
      in_x = 1'b0;
    end else if (cs_n != 8'hFF) begin
      if (!in_x) begin
        in_x = 1'b1;
        cyc = 0;
        ack_seen = 1'b0;
        if (q.size() == 0) begin
          chk(1'b0, "R11 unexpected select", {24'h0, cs_n}, 32'hFF);
          cur.idx = -1;
        end else begin
          cur = q.pop_front();
          chk(cs_n == ~(8'h01 << cur.idx), {cur.tag, " select"},
              {24'h0, cs_n}, {24'h0, ~(8'h01 << cur.idx)});
          chk(dir_wr == cur.wr, "R7 direction", {31'h0, dir_wr}, {31'h0, cur.wr});
          chk(pwidth == cur.wd, "R8 width", {30'h0, pwidth}, {30'h0, cur.wd});
          chk(burst == cur.bst, "R8 burst", {31'h0, burst}, {31'h0, cur.bst});
        end
      end else begin
        cyc++;
      end
      if (ack && cur.idx >= 0) begin
        ack_seen = 1'b1;
        chk(cyc == cur.wst + 1, "R6 ack cycle", cyc, cur.wst + 1);
      end
    end else if (in_x) begin
      in_x = 1'b0;
      if (cur.idx >= 0) chk(ack_seen, "R6 ack seen", {31'h0, ack_seen}, 32'h1);
    end
  end

  // ---------------- driver tasks -------------------------------------------
  task automatic reg_wr(input int idx, input logic [1:0] slot, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx[2:0]; cfg_reg = slot; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic reg_rd(input int idx, input logic [1:0] slot,
                        input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_idx = idx[2:0]; cfg_reg = slot;
    @(negedge clk);
    chk(cfg_rdata == exp, tag, cfg_rdata, exp);
  endtask

  task automatic access(input logic [31:0] a, input bit w, input int idx,
                        input int wst, input logic [1:0] wd, input bit b,
                        input string tag);
    @(negedge clk);
    bus_addr = a; bus_write = w; bus_req = 1'b1;
    if (idx >= 0) begin
      exp_t e;
      e.idx = idx; e.wr = w; e.wd = wd; e.bst = b; e.wst = wst; e.tag = tag;
      q.push_back(e);
    end
    @(negedge clk);
    bus_req = 1'b0;
    if (idx < 0) begin
      for (int k = 0; k < 3; k++) begin
        chk(cs_n == 8'hFF && !ack, tag, {23'h0, ack, cs_n}, 32'hFF);
        @(negedge clk);
      end
    end else begin
      while (!ack) @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_reset(input logic [1:0] s);
    @(negedge clk);
    strap = s; rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(cs_n == 8'hFF && !ack, "R1 in reset", {23'h0, ack, cs_n}, 32'hFF);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n == 8'hFF && !ack, "R1 after reset", {23'h0, ack, cs_n}, 32'hFF);
  endtask

  // ---------------- watchdog -----------------------------------------------
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------------------------------------
  initial begin
    do_reset(2'b01);
    // R1 R2 R10: boot select state, others cleared
    reg_rd(0, 2'd2, 32'h0000_00F3, "R2 boot ctrl strap 01");
    reg_rd(0, 2'd1, 32'hFFFF_FFFF, "R1 boot mask");
    reg_rd(3, 2'd2, 32'h0000_0000, "R1 select 3 ctrl");
    access(32'h1234_5678, 1'b0, 0, 15, 2'b01, 1'b0, "R1 global boot");

    // shrink select 0 to 1 MB, width 32, burst, 2 waits
    reg_wr(0, 2'd1, 32'h000F_FFFF);
    reg_wr(0, 2'd2, 32'h0000_0029);
    access(32'h0008_0000, 1'b1, 0, 2, 2'b00, 1'b1, "R3 select 0 moved");

    // R4: programmed but disabled select
    reg_wr(3, 2'd0, 32'h4000_0000);
    reg_wr(3, 2'd1, 32'h00FF_FFFF);
    reg_wr(3, 2'd2, 32'h0000_0004);
    reg_rd(3, 2'd0, 32'h4000_0000, "R10 base readback");
    reg_rd(3, 2'd1, 32'h00FF_FFFF, "R10 mask readback");
    access(32'h4000_0010, 1'b0, -1, 0, 2'b00, 1'b0, "R4 disabled select");

    // R3 R6 R8: enable it, width 16, no waits
    reg_wr(3, 2'd2, 32'h0000_0005);
    access(32'h40AB_CDEF, 1'b0, 3, 0, 2'b10, 1'b0, "R3 masked match");
    access(32'h4100_0000, 1'b0, -1, 0, 2'b00, 1'b0, "R3 outside window");

    // R5: overlapping select 5, width 8, 3 waits
    reg_wr(5, 2'd0, 32'h4000_0000);
    reg_wr(5, 2'd1, 32'h0FFF_FFFF);
    reg_wr(5, 2'd2, 32'h0000_0033);
    access(32'h4000_0004, 1'b1, 3, 0, 2'b10, 1'b0, "R5 lower index wins");
    access(32'h4200_0000, 1'b0, 5, 3, 2'b01, 1'b0, "R5 only upper matches");

    // R9: SDRAM bit ignored on select 2, honoured on select 7
    reg_wr(2, 2'd0, 32'h8000_0000);
    reg_wr(2, 2'd1, 32'h0000_FFFF);
    reg_wr(2, 2'd2, 32'h0000_0101);
    reg_rd(2, 2'd2, 32'h0000_0001, "R9 sdram bit dropped");
    access(32'h8000_0100, 1'b1, 2, 0, 2'b00, 1'b0, "R9 select 2 still decodes");
    reg_wr(7, 2'd0, 32'hC000_0000);
    reg_wr(7, 2'd1, 32'h0000_FFFF);
    reg_wr(7, 2'd2, 32'h0000_0101);
    reg_rd(7, 2'd2, 32'h0000_0101, "R9 sdram bit kept");
    access(32'hC000_0040, 1'b0, -1, 0, 2'b00, 1'b0, "R9 sdram select skipped");
    reg_wr(7, 2'd2, 32'h0000_0001);
    access(32'hC000_0040, 1'b0, 7, 0, 2'b00, 1'b0, "R9 select 7 normal");

    // R11: second request during a 5-wait access
    reg_wr(1, 2'd0, 32'h2000_0000);
    reg_wr(1, 2'd1, 32'h0000_FFFF);
    reg_wr(1, 2'd2, 32'h0000_0051);
    begin
      exp_t e;
      @(negedge clk);
      bus_addr = 32'h2000_0010; bus_write = 1'b0; bus_req = 1'b1;
      e.idx = 1; e.wr = 1'b0; e.wd = 2'b00; e.bst = 1'b0; e.wst = 5;
      e.tag = "R11 first access";
      q.push_back(e);
      @(negedge clk);
      bus_req = 1'b0;
      @(negedge clk);
      bus_addr = 32'h40AB_0000; bus_write = 1'b1; bus_req = 1'b1;
      @(negedge clk);
      bus_req = 1'b0;
      while (!ack) @(negedge clk);
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
        chk(cs_n == 8'hFF, "R11 busy request dropped", {24'h0, cs_n}, 32'hFF);
        @(negedge clk);
      end
    end

    // R2: reserved and 16-bit straps
    do_reset(2'b11);
    reg_rd(0, 2'd2, 32'h0000_00F1, "R2 strap 11 stored as 32");
    reg_rd(5, 2'd2, 32'h0000_0000, "R1 select 5 cleared");
    access(32'hDEAD_BEEF, 1'b1, 0, 15, 2'b00, 1'b0, "R2 strap 11 access");
    do_reset(2'b10);
    reg_rd(0, 2'd2, 32'h0000_00F5, "R2 strap 10 ctrl");
    access(32'h0000_0000, 1'b0, 0, 15, 2'b10, 1'b0, "R2 strap 10 access");

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R6 all accesses seen", q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule